// File: doc/BRIEF.md
# Majority-Vote Oversampling Serial Receiver

This block recovers bytes from an asynchronous serial line. It works from a receive tick that runs at sixteen times the bit rate, so every bit occupies a cell of sixteen ticks, numbered 0 to 15. While idle, the receiver looks at the synchronised line on every tick. The first tick that finds the line low becomes tick 0 of the start bit. From that point every bit is decided by a 2-of-3 vote over the line values seen at ticks 7, 8 and 9 of its cell. This applies to the start bit, the data bits, the optional parity bit and the stop bits.

The receive tick comes from one of two places. A free-running prescaler feeds a ladder of six rates, each half the one before it. A 3-bit rate select picks one of these rates, or it picks the pulses of an external timer. A frame holds a start bit, eight data bits sent least significant bit first, an optional parity bit (odd or even) and one or two stop bits. When the final stop bit has been voted, the receiver presents the byte with a one-cycle strobe and two error flags, then goes back to looking for a start bit. The serial input passes through a two-flop synchroniser before any sampling. The frame-format inputs must be held steady while a frame is being received.

Top module: `uart_vote_rx`

## Requirements
- R1: After reset the receiver is idle: `rx_valid`, `rx_parity_err` and `rx_frame_err` are 0 and `rx_data` is 0x00.
- R2: Rate select codes 0 to 5 give one receive tick every BASE_DIV·2^code clock cycles. Code 6 makes each one-cycle `ext_tick` pulse a receive tick. Code 7 gives no ticks, so no frame is received.
- R3: While idle, the first tick that finds the synchronised line low is tick 0 of the start bit, and all later cells are counted from it in steps of 16 ticks.
- R4: Each bit takes the value held by at least two of the three line samples at ticks 7, 8 and 9 of its cell. Line values at every other tick of the cell have no effect.
- R5: If the start bit is voted high, the frame is dropped without any strobe or error flag, and the receiver goes back to idle.
- R6: The eight data bits are received least significant bit first. `rx_data` holds the byte from the strobe until the next strobe.
- R7: With `par_en`=1, one parity bit follows the data. `par_odd`=0 selects even parity (the data bits plus the parity bit hold an even number of ones) and `par_odd`=1 selects odd parity. `rx_parity_err` is 1 when the voted bits break the selected rule. With `par_en`=0 it is 0.
- R8: `two_stop`=0 selects one stop bit and `two_stop`=1 selects two. `rx_frame_err` is 1 when any voted stop bit is low.
- R9: `rx_valid` is high for exactly one clock cycle per accepted frame, in the cycle after tick 9 of the final stop bit. The two error flags are 0 in every cycle in which `rx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_serial | input | 1 | Asynchronous serial line, high when idle |
| rate_sel | input | 3 | Receive tick source: ladder rung 0..5, 6 external, 7 off |
| ext_tick | input | 1 | One-cycle external timer pulse, used when rate_sel is 6 |
| par_en | input | 1 | A parity bit follows the data |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for a received frame |
| rx_parity_err | output | 1 | Parity mismatch, valid with the strobe |
| rx_frame_err | output | 1 | A stop bit was voted low, valid with the strobe |

## Verification
The bench drives most frames through the external tick, so it knows which tick every line value lands on. It flips single samples inside the 7..9 window, which a design voting on one sample or on the wrong ticks would turn into a corrupted byte. It flips pairs inside the window, which must invert the bit, and flips every tick outside the window, which must change nothing. Start bits that fall back high at tick 7, or at tick 8 with ticks 9 onward high, must be dropped silently. A design that started on any low level would instead deliver a spurious byte. Bad parity, a low first or second stop bit, and the ladder rates including the off code are each set up so that a wrong bit order, a missing second stop check or a wrong divider shows up as a wrong byte, a wrong flag or a missing strobe.

// File: rtl/uvr_pkg.sv
package uvr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_t;

  // 2-of-3 majority of three line samples
  function automatic logic vote3(input logic [2:0] s);
    return (s[0] & s[1]) | (s[0] & s[2]) | (s[1] & s[2]);
  endfunction

endpackage

// File: rtl/uvr_tick_sel.sv
module uvr_tick_sel #(
  parameter int BASE_DIV = 13,
  parameter int RUNGS    = 6,
  parameter int SEL_W    = 3,
  parameter int EXT_CODE = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             ext_tick,
  output logic             tick
);
  localparam int PW    = $clog2(BASE_DIV + 1);
  localparam int LAD_W = (RUNGS > 1) ? RUNGS - 1 : 1;
  localparam int CODES = 2 ** SEL_W;

  logic [PW-1:0]    pre;
  logic [LAD_W-1:0] lad;
  logic             base_hit;
  logic [CODES-1:0] code_tick;

  // rung k fires on every 2^k-th base pulse
  function automatic logic rung_hit(input logic [LAD_W-1:0] cnt, input int k);
    logic [LAD_W:0] m;
    m = ((LAD_W+1)'(1) << k) - (LAD_W+1)'(1);
    return (cnt & m[LAD_W-1:0]) == '0;
  endfunction

  assign base_hit = (pre == PW'(BASE_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      lad <= '0;
    end else begin
      pre <= base_hit ? '0 : pre + 1'b1;
      if (base_hit) lad <= lad + 1'b1;
    end
  end

  for (genvar g = 0; g < CODES; g++) begin : g_code
    if (g < RUNGS) begin : g_rung
      assign code_tick[g] = base_hit && rung_hit(lad, g);
    end else if (g == EXT_CODE) begin : g_ext
      assign code_tick[g] = ext_tick;
    end else begin : g_off
      assign code_tick[g] = 1'b0;
    end
  end

  assign tick = code_tick[rate_sel];

endmodule

// File: rtl/uvr_sync.sv
module uvr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '1;
    else        sh <= {sh[STAGES-2:0], din};
  end

  assign dout = sh[STAGES-1];

endmodule

// File: rtl/uvr_frame.sv
module uvr_frame
  import uvr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16,
  parameter int MID    = 8,
  localparam int PH_W  = $clog2(OVS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxs,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic [DATA_W-1:0] data_out,
  output logic              valid,
  output logic              perr,
  output logic              ferr,
  output logic              in_idle,
  output logic [PH_W-1:0]   phase,
  output logic              vote_strobe,
  output logic              start_seen,
  output logic              glitch_abort
);
  localparam int BI_W = $clog2(DATA_W);
  localparam logic [PH_W-1:0] PH_FIRST = PH_W'(MID - 1);
  localparam logic [PH_W-1:0] PH_LAST  = PH_W'(MID + 1);
  localparam logic [PH_W-1:0] PH_END   = PH_W'(OVS - 1);

  rx_state_t         state;
  logic [1:0]        samp;
  logic [DATA_W-1:0] shreg;
  logic [BI_W-1:0]   bidx;
  logic              pbit;
  logic              stop_idx;
  logic              ferr_acc;
  logic              active, take, cell_end, v, last_stop;

  // mismatch against the selected rule over data plus parity bit
  function automatic logic par_mismatch(input logic [DATA_W-1:0] d,
                                        input logic p, input logic odd);
    return (^{d, p}) != odd;
  endfunction

  assign in_idle      = (state == ST_IDLE);
  assign active       = tick && !in_idle;
  assign take         = active && (phase >= PH_FIRST) && (phase <= PH_LAST);
  assign vote_strobe  = active && (phase == PH_LAST);
  assign cell_end     = active && (phase == PH_END);
  assign start_seen   = tick && in_idle && !rxs;
  assign v            = vote3({samp, rxs});
  assign glitch_abort = vote_strobe && (state == ST_START) && v;
  assign last_stop    = (state == ST_STOP) && (stop_idx == two_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      phase    <= '0;
      samp     <= '0;
      shreg    <= '0;
      bidx     <= '0;
      pbit     <= 1'b0;
      stop_idx <= 1'b0;
      ferr_acc <= 1'b0;
      data_out <= '0;
      valid    <= 1'b0;
      perr     <= 1'b0;
      ferr     <= 1'b0;
    end else begin
      valid <= 1'b0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      if (start_seen) begin
        state    <= ST_START;
        phase    <= PH_W'(1);
        ferr_acc <= 1'b0;
        pbit     <= 1'b0;
      end else if (active) begin
        phase <= (phase == PH_END) ? '0 : phase + 1'b1;
        if (take) samp <= {samp[0], rxs};
        if (vote_strobe) begin
          case (state)
            ST_START: if (v) state <= ST_IDLE;
            ST_DATA:  shreg <= {v, shreg[DATA_W-1:1]};
            ST_PAR:   pbit <= v;
            ST_STOP: begin
              if (last_stop) begin
                valid    <= 1'b1;
                data_out <= shreg;
                ferr     <= ferr_acc | !v;
                perr     <= par_en && par_mismatch(shreg, pbit, par_odd);
                state    <= ST_IDLE;
              end else begin
                ferr_acc <= ferr_acc | !v;
              end
            end
            default: ;
          endcase
        end
        if (cell_end) begin
          case (state)
            ST_START: begin
              state <= ST_DATA;
              bidx  <= '0;
            end
            ST_DATA: begin
              if (bidx == BI_W'(DATA_W - 1)) begin
                state    <= par_en ? ST_PAR : ST_STOP;
                stop_idx <= 1'b0;
              end else begin
                bidx <= bidx + 1'b1;
              end
            end
            ST_PAR: begin
              state    <= ST_STOP;
              stop_idx <= 1'b0;
            end
            ST_STOP: stop_idx <= 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx #(
  parameter int BASE_DIV = 13,
  parameter int RUNGS    = 6,
  parameter int OVS      = 16,
  parameter int MID      = 8,
  parameter int DATA_W   = 8,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_serial,
  input  logic [2:0]        rate_sel,
  input  logic              ext_tick,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              two_stop,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_parity_err,
  output logic              rx_frame_err
);
  localparam int PH_W = $clog2(OVS);

  logic            tick;
  logic            rxs;
  logic            in_idle;
  logic [PH_W-1:0] phase;
  logic            vote_strobe;
  logic            start_seen;
  logic            glitch_abort;

  uvr_tick_sel #(
    .BASE_DIV(BASE_DIV), .RUNGS(RUNGS), .SEL_W(3), .EXT_CODE(6)
  ) u_tick (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .ext_tick(ext_tick), .tick(tick)
  );

  uvr_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rx_serial), .dout(rxs)
  );

  uvr_frame #(.DATA_W(DATA_W), .OVS(OVS), .MID(MID)) u_frame (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxs(rxs),
    .par_en(par_en), .par_odd(par_odd), .two_stop(two_stop),
    .data_out(rx_data), .valid(rx_valid),
    .perr(rx_parity_err), .ferr(rx_frame_err),
    .in_idle(in_idle), .phase(phase), .vote_strobe(vote_strobe),
    .start_seen(start_seen), .glitch_abort(glitch_abort)
  );

endmodule

// File: rtl/uvr_checker.sv
module uvr_checker #(
  parameter int PH_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic [2:0]      rate_sel,
  input logic            ext_tick,
  input logic            tick,
  input logic [PH_W-1:0] phase,
  input logic            in_idle,
  input logic            start_seen,
  input logic            glitch_abort,
  input logic            vote_strobe,
  input logic            rx_valid,
  input logic            rx_parity_err,
  input logic            rx_frame_err
);

  assert_off_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 3'd7) |-> !tick);

  assert_ext_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 3'd6 && !ext_tick) |-> !tick);

  assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase));

  assert_start_cell_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (!in_idle && phase == PH_W'(1)));

  assert_glitch_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    glitch_abort |=> (in_idle && !rx_valid));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_valid_after_vote_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(vote_strobe));

  assert_flags_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> (!rx_parity_err && !rx_frame_err));

endmodule

bind uart_vote_rx uvr_checker #(.PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .ext_tick(ext_tick),
  .tick(tick), .phase(phase), .in_idle(in_idle), .start_seen(start_seen),
  .glitch_abort(glitch_abort), .vote_strobe(vote_strobe),
  .rx_valid(rx_valid), .rx_parity_err(rx_parity_err),
  .rx_frame_err(rx_frame_err)
);

// File: tb/tb_uart_vote_rx.sv
module tb_uart_vote_rx;
  localparam int BASE_DIV = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_serial = 1'b1;
  logic [2:0] rate_sel = 3'd6;
  logic       ext_tick = 1'b0;
  logic       par_en = 1'b0, par_odd = 1'b0, two_stop = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_parity_err, rx_frame_err;

  int checks = 0, fails = 0;
  int vcnt = 0, stray = 0;
  logic [7:0] cap_data = 8'h00;
  logic cap_perr = 1'b0, cap_ferr = 1'b0;
  logic [15:0] flip [12];

  always #2 clk = ~clk;

  uart_vote_rx #(.BASE_DIV(BASE_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .rx_serial(rx_serial), .rate_sel(rate_sel),
    .ext_tick(ext_tick), .par_en(par_en), .par_odd(par_odd),
    .two_stop(two_stop), .rx_data(rx_data), .rx_valid(rx_valid),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        vcnt++;
        cap_data = rx_data;
        cap_perr = rx_parity_err;
        cap_ferr = rx_frame_err;
      end else if (rx_parity_err || rx_frame_err) begin
        stray++;
      end
    end
  end

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic vote_exp(input logic b, input logic [15:0] f);
    int c;
    c = int'(f[7]) + int'(f[8]) + int'(f[9]);
    return (c >= 2) ? ~b : b;
  endfunction

  function automatic logic par_exp(input logic [7:0] d, input logic p, input logic odd);
    int ones;
    ones = int'(p);
    for (int i = 0; i < 8; i++) ones += int'(d[i]);
    return odd ? (ones % 2 == 0) : (ones % 2 == 1);
  endfunction

  // one receive tick carrying line value lv
  task automatic slot(input logic lv);
    @(negedge clk) rx_serial = lv;
    repeat (3) @(negedge clk);
    ext_tick = 1'b1;
    @(negedge clk) ext_tick = 1'b0;
  endtask

  task automatic clear_flip;
    for (int i = 0; i < 12; i++) flip[i] = 16'h0000;
  endtask

  task automatic run_ext(input logic [7:0] d, input bit pe, input bit po,
                         input bit pbad, input bit ts, input logic [1:0] sbad,
                         input string rq);
    logic bits [12];
    int n, v0, s0;
    logic [7:0] ed;
    logic ep, es1, es2, eperr, eferr, pb;
    rate_sel = 3'd6;
    par_en = pe; par_odd = po; two_stop = ts;
    pb = (^d) ^ po ^ pbad;
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    n = 9;
    if (pe) begin bits[9] = pb; n = 10; end
    s0 = n;
    bits[n] = ~sbad[0]; n++;
    if (ts) begin bits[n] = ~sbad[1]; n++; end
    for (int i = 0; i < 8; i++) ed[i] = vote_exp(bits[i+1], flip[i+1]);
    ep = pe ? vote_exp(pb, flip[9]) : 1'b0;
    es1 = vote_exp(bits[s0], flip[s0]);
    es2 = ts ? vote_exp(bits[s0+1], flip[s0+1]) : 1'b1;
    eperr = pe && par_exp(ed, ep, po);
    eferr = !es1 || !es2;
    v0 = vcnt;
    for (int i = 0; i < n; i++) begin
      for (int s = 0; s < 16; s++) begin
        logic lv;
        lv = bits[i] ^ flip[i][s];
        if (i == n - 1 && s >= 10) lv = 1'b1;
        slot(lv);
      end
    end
    repeat (3) slot(1'b1);
    chk(vcnt - v0 == 1, "R9", "strobe cycles", vcnt - v0, 1);
    chk(cap_data == ed, rq, "data", int'(cap_data), int'(ed));
    chk(cap_perr == eperr, "R7", "parity flag", int'(cap_perr), int'(eperr));
    chk(cap_ferr == eferr, "R8", "frame flag", int'(cap_ferr), int'(eferr));
    clear_flip();
  endtask

  // start bit low for lowslots ticks, then high: R5
  task automatic run_glitch(input int lowslots);
    int v0;
    rate_sel = 3'd6;
    v0 = vcnt;
    for (int s = 0; s < 16; s++) slot(s < lowslots ? 1'b0 : 1'b1);
    repeat (20) slot(1'b1);
    chk(vcnt == v0, "R5", "strobes after glitch", vcnt - v0, 0);
    chk(stray == 0, "R5", "flags after glitch", stray, 0);
  endtask

  // frame timed by the ladder rate of code k (code 7 timed as code 0): R2
  task automatic run_ladder(input logic [2:0] k, input logic [7:0] d, input bit expect_rx);
    int bitclk, v0;
    logic bits [10];
    rate_sel = k;
    par_en = 1'b0; two_stop = 1'b0;
    bitclk = 16 * BASE_DIV * (1 << ((k == 3'd7) ? 0 : int'(k)));
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    bits[9] = 1'b1;
    v0 = vcnt;
    repeat (bitclk) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk) rx_serial = bits[i];
      repeat (bitclk - 1) @(negedge clk);
    end
    repeat (2 * bitclk) @(negedge clk);
    chk(vcnt - v0 == (expect_rx ? 1 : 0), "R2", "ladder strobes", vcnt - v0, expect_rx ? 1 : 0);
    if (expect_rx) chk(cap_data == d, "R2", "ladder data", int'(cap_data), int'(d));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired (R9 strobe never completed)");
    report();
  end

  initial begin
    logic [7:0] d;
    int n, r;
    bit pe, po, ts, pbad;
    logic [1:0] sbad;
    void'($urandom(32'h5eed_1234));
    clear_flip();
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(rx_valid == 1'b0, "R1", "valid in reset", int'(rx_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(rx_valid == 1'b0 && rx_parity_err == 1'b0 && rx_frame_err == 1'b0,
        "R1", "flags after reset", int'({rx_valid, rx_parity_err, rx_frame_err}), 0);
    chk(rx_data == 8'h00, "R1", "data after reset", int'(rx_data), 0);

    repeat (8) slot(1'b1);
    // R3 / R6: plain frames, bit order
    run_ext(8'h01, 0, 0, 0, 0, 2'b00, "R6");
    run_ext(8'h80, 0, 0, 0, 0, 2'b00, "R6");
    run_ext(8'hA5, 0, 0, 0, 0, 2'b00, "R3");
    // R7 parity modes
    run_ext(8'h03, 1, 0, 0, 0, 2'b00, "R7");
    run_ext(8'h03, 1, 0, 1, 0, 2'b00, "R7");
    run_ext(8'h07, 1, 1, 0, 0, 2'b00, "R7");
    run_ext(8'h07, 1, 1, 1, 1, 2'b00, "R7");
    // R8 stop bits
    run_ext(8'h5A, 0, 0, 0, 0, 2'b01, "R8");
    run_ext(8'h5A, 0, 0, 0, 1, 2'b10, "R8");
    run_ext(8'h5A, 1, 0, 0, 1, 2'b01, "R8");
    // R4 voting window
    flip[1] = 16'h0080; flip[3] = 16'h0100; flip[5] = 16'h0200;
    run_ext(8'h3C, 0, 0, 0, 0, 2'b00, "R4");
    flip[2] = 16'h0180; flip[4] = 16'h0300; flip[6] = 16'h0280;
    run_ext(8'h3C, 0, 0, 0, 0, 2'b00, "R4");
    flip[3] = 16'hFC7F; flip[7] = 16'hFC7E;
    run_ext(8'hC3, 0, 0, 0, 0, 2'b00, "R4");
    // R5 start glitches, and a start that survives 2-of-3
    run_glitch(1);
    run_glitch(7);
    run_glitch(8);
    flip[0] = 16'hFE00;
    run_ext(8'h96, 0, 0, 0, 0, 2'b00, "R5");
    // R2 rate ladder and off code
    run_ladder(3'd0, 8'h6B, 1);
    run_ladder(3'd1, 8'hD2, 1);
    run_ladder(3'd2, 8'h4E, 1);
    run_ladder(3'd7, 8'h11, 0);
    // random frames with noise (R4, R6, R7, R8)
    for (int f = 0; f < 30; f++) begin
      d = 8'($urandom);
      pe = bit'($urandom % 2); po = bit'($urandom % 2);
      ts = bit'($urandom % 2); pbad = bit'($urandom % 2);
      sbad = 2'b00;
      if ($urandom % 8 == 0) sbad[0] = 1'b1;
      if ($urandom % 8 == 0) sbad[1] = 1'b1;
      n = 10 + int'(pe) + int'(ts);
      for (int i = 1; i < n; i++) begin
        r = int'($urandom % 8);
        if (r < 3) flip[i] = 16'h0080 << r;
        else if (r == 3) flip[i] = 16'h0280;
        flip[i] = flip[i] | (16'($urandom) & 16'hFC7E);
      end
      run_ext(d, pe, po, pbad, ts, sbad, "R6");
    end
    chk(stray == 0, "R9", "flags without strobe", stray, 0);
    report();
  end

endmodule